// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus that serves a 2048-location, 8-bit memory held in registers. It synchronizes the clock and data lines to the system clock and recognises start and stop conditions. It then decodes a device-select byte: a fixed 4-bit device code, three page bits and a direction bit. In write mode it takes an 11-bit word address and up to one page of data bytes. The page bits from the select byte give the top three address bits and the next byte gives the lower eight. In read mode it sends bytes from an internal address pointer for as long as the master acknowledges them.

Data bytes are gathered in a 16-entry page buffer and go into the array only after a stop condition. The commit keeps the block busy for a fixed, parameterised number of system clocks, and during that time it will not acknowledge its device-select byte. A write-protect input stops data bytes from reaching the buffer. The data line is driven only through an active-high pull-low enable, as an open-drain pad needs.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block responds to nothing until it has seen a start condition, which is SDA falling while SCL is high. Clocking a device-select byte without a start condition gets no acknowledge.
- R2: Every transfer is 8 bits followed by an acknowledge on the 9th SCL clock. The slave pulls SDA low only by raising sda_oe_o, and it changes sda_oe_o only while SCL is low. It never pulls SDA while SCL is high outside an acknowledge bit or a read data bit of its own.
- R3: The slave answers a device-select byte only if bits 7:4 equal binary 1010. With any other code it stays released until the next start condition.
- R4: For a write, select-byte bits 3:1 form word-address bits 10:8 and the next byte forms bits 7:0.
- R5: Select-byte bit 0 sets the direction: 0 means write (this includes the address-only write that comes before a random read) and 1 means read. A read starts at the current pointer and ignores the page bits.
- R6: The slave acknowledges (drives SDA low) after a matching select byte, after the word-address byte and after each write data byte.
- R7: During a read the slave sends a new byte after each master acknowledge. After a master not-acknowledge it keeps SDA released until a stop or start condition.
- R8: After reset every location reads 0xFF and sda_oe_o is low.
- R9: A data byte received while wp_i is high is still acknowledged but does not change the array.
- R10: The pointer advances by one after each byte sent. It wraps from 0x7FF to 0x000, and a read without a new address continues from where the previous read stopped.
- R11: During a write, the address advances within its 16-byte page: after the offset 0xF byte, the next byte goes to offset 0x0 of the same page.
- R12: Buffered data is written to the array at the stop condition. For PROG_CYCLES clocks after that stop, the slave does not acknowledge a select byte. Afterwards it does, and the new data reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| wp_i | input | 1 | Write protect; high blocks data bytes from the array |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |

## Verification
The case that is hardest to reach from the pins is the busy window after a commit. A select byte can hit that window only if a new start condition follows a data-carrying stop within PROG_CYCLES clocks. The bench therefore issues a new start and select byte straight after the stop and expects a not-acknowledge, then waits past the window and expects an acknowledge and the committed data. A second hard case is the released bus after a master not-acknowledge. The bench keeps clocking a full byte with SDA released, checks that the line still reads back 0xFF, and a per-clock monitor flags any pull-low while SCL is high in a phase where the slave has no right to drive.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT_STOP
    } bus_state_e;

    typedef enum logic [1:0] {
        BY_SELECT,
        BY_WADDR,
        BY_WDATA
    } byte_kind_e;

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_d, sh_q;
        logic              prev_d, prev_q;

        always_comb begin
            sh_d   = {sh_q[STAGES-2:0], raw_i[g]};
            prev_d = sh_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q   <= '1;
                prev_q <= 1'b1;
            end else begin
                sh_q   <= sh_d;
                prev_q <= prev_d;
            end
        end

        assign lvl_o[g]  = sh_q[STAGES-1];
        assign rise_o[g] = sh_q[STAGES-1] & ~prev_q;
        assign fall_o[g] = ~sh_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_off_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PAGE_W-1:0] rd_off_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic              any_valid_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            data_d [PAGE_BYTES];
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr_i) begin
            valid_d = '0;
        end else if (wr_i) begin
            data_d[wr_off_i]  = wr_data_i;
            valid_d[wr_off_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) data_q[i] <= 8'h00;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign rd_data_o   = data_q[rd_off_i];
    assign rd_valid_o  = valid_q[rd_off_i];
    assign any_valid_o = |valid_q;

endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    // Storage is a single registered process: a next-state copy of every
    // location would double the array for no gain.
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= 8'hFF;
        end else if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         PAGE_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         PROG_CYCLES = 1000,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    localparam int PG_BITS = ADDR_W - 8;
    localparam int PC_W    = $clog2(PROG_CYCLES + 1);
    localparam int HI_W    = ADDR_W - PAGE_W;

    typedef struct packed {
        bus_state_e          st;
        byte_kind_e          kind;
        logic [3:0]          cnt;
        logic [7:0]          shreg;
        logic                rw;
        logic [PG_BITS-1:0]  pg;
        logic [ADDR_W-1:0]   ptr;
        logic                oe;
        logic                acked;
        logic [PC_W-1:0]     prog_cnt;
        logic [PAGE_W:0]     cidx;
        logic [HI_W-1:0]     cpage;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // synchronized lines: bit 1 = SCL, bit 0 = SDA
    logic [1:0] lvl, rise, fall;
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic       start_evt, stop_evt, busy;

    eeprom_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl   = lvl[1];
    assign sda_lvl   = lvl[0];
    assign scl_rise  = rise[1];
    assign scl_fall  = fall[1];
    assign start_evt = scl_lvl & fall[0];
    assign stop_evt  = scl_lvl & rise[0];
    assign busy      = (ctl_q.prog_cnt != '0);

    // page buffer
    logic              buf_clr, buf_wr;
    logic [PAGE_W-1:0] buf_wr_off;
    logic [7:0]        buf_wr_data;
    logic [7:0]        buf_rd_data;
    logic              buf_rd_valid, buf_any;

    eeprom_page_buf #(.PAGE_W(PAGE_W)) pbuf_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (buf_clr),
        .wr_i        (buf_wr),
        .wr_off_i    (buf_wr_off),
        .wr_data_i   (buf_wr_data),
        .rd_off_i    (ctl_q.cidx[PAGE_W-1:0]),
        .rd_data_o   (buf_rd_data),
        .rd_valid_o  (buf_rd_valid),
        .any_valid_o (buf_any)
    );

    // array
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_rdata;

    assign mem_raddr = ctl_q.ptr;

    eeprom_cell_array #(.ADDR_W(ADDR_W)) cells_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (buf_rd_data),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        ctl_d       = ctl_q;
        buf_clr     = 1'b0;
        buf_wr      = 1'b0;
        buf_wr_off  = ctl_q.ptr[PAGE_W-1:0];
        buf_wr_data = ctl_q.shreg;
        mem_we      = 1'b0;
        mem_waddr   = {ctl_q.cpage, ctl_q.cidx[PAGE_W-1:0]};

        // commit engine: one buffer slot per clock, then idle out the window
        if (busy) begin
            ctl_d.prog_cnt = ctl_q.prog_cnt - PC_W'(1);
            if (!ctl_q.cidx[PAGE_W]) begin
                mem_we     = buf_rd_valid;
                ctl_d.cidx = ctl_q.cidx + (PAGE_W+1)'(1);
            end
            if (ctl_q.prog_cnt == PC_W'(1)) buf_clr = 1'b1;
        end

        if (start_evt) begin
            ctl_d.st   = ST_RX;
            ctl_d.kind = BY_SELECT;
            ctl_d.cnt  = '0;
            ctl_d.oe   = 1'b0;
            if (!busy) buf_clr = 1'b1;
        end else if (stop_evt) begin
            ctl_d.st = ST_IDLE;
            ctl_d.oe = 1'b0;
            if (!busy && buf_any) begin
                ctl_d.prog_cnt = PC_W'(PROG_CYCLES);
                ctl_d.cidx     = '0;
                ctl_d.cpage    = ctl_q.ptr[ADDR_W-1:PAGE_W];
            end
        end else begin
            unique case (ctl_q.st)
                ST_RX: begin
                    if (scl_rise && ctl_q.cnt != 4'd8) begin
                        ctl_d.shreg = {ctl_q.shreg[6:0], sda_lvl};
                        ctl_d.cnt   = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        unique case (ctl_q.kind)
                            BY_SELECT: begin
                                if (ctl_q.shreg[7:4] == DEV_CODE && !busy) begin
                                    ctl_d.rw = ctl_q.shreg[0];
                                    ctl_d.pg = ctl_q.shreg[PG_BITS:1];
                                    ctl_d.oe = 1'b1;
                                    ctl_d.st = ST_RX_ACK;
                                end else begin
                                    ctl_d.st = ST_WAIT_STOP;
                                end
                            end
                            BY_WADDR: begin
                                ctl_d.ptr  = {ctl_q.pg, ctl_q.shreg};
                                ctl_d.kind = BY_WDATA;
                                ctl_d.oe   = 1'b1;
                                ctl_d.st   = ST_RX_ACK;
                            end
                            default: begin
                                buf_wr    = !wp_i;
                                ctl_d.ptr = {ctl_q.ptr[ADDR_W-1:PAGE_W],
                                             ctl_q.ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                ctl_d.oe  = 1'b1;
                                ctl_d.st  = ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        ctl_d.cnt = '0;
                        ctl_d.oe  = 1'b0;
                        ctl_d.st  = ST_RX;
                        if (ctl_q.kind == BY_SELECT) begin
                            if (ctl_q.rw) begin
                                ctl_d.shreg = mem_rdata;
                                ctl_d.ptr   = ctl_q.ptr + ADDR_W'(1);
                                ctl_d.oe    = ~mem_rdata[7];
                                ctl_d.st    = ST_TX;
                            end else begin
                                ctl_d.kind = BY_WADDR;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 4'd7) begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = ST_TX_ACK;
                        end else begin
                            ctl_d.cnt   = ctl_q.cnt + 4'd1;
                            ctl_d.shreg = {ctl_q.shreg[6:0], 1'b0};
                            ctl_d.oe    = ~ctl_q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        ctl_d.acked = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (ctl_q.acked) begin
                            ctl_d.shreg = mem_rdata;
                            ctl_d.ptr   = ctl_q.ptr + ADDR_W'(1);
                            ctl_d.oe    = ~mem_rdata[7];
                            ctl_d.cnt   = '0;
                            ctl_d.st    = ST_TX;
                        end else begin
                            ctl_d.st = ST_WAIT_STOP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, kind: BY_SELECT, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_lvl,
    input logic              stop_evt,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr
);

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl)) else $error("oe moved with SCL high"); // R2

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe) else $error("line held after stop"); // R7

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe) else $error("drive during commit"); // R12

    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy) else $error("array write outside commit"); // R12

    AST_PTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr)) else $error("pointer moved in commit"); // R10

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .scl_lvl  (scl_lvl),
    .stop_evt (stop_evt),
    .busy     (busy),
    .mem_we   (mem_we),
    .ptr      (mem_raddr)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;

    localparam int Q    = 10;    // clocks per quarter bit
    localparam int WAIT = 1100;  // clocks beyond the commit window

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_eeprom_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    bit may_drive = 1'b0;

    // reference model: expected array contents and pointer
    logic [7:0] model_mem [int];
    int         model_ptr = 0;

    function automatic logic [7:0] exp_at(input int a);
        if (model_mem.exists(a & 'h7FF)) return model_mem[a & 'h7FF];
        return 8'hFF;
    endfunction

    // per-clock bus check: slave may pull SCL-high SDA only in its own phases (R2)
    always @(negedge clk) begin
        if (rst_n && sda_oe && m_scl && !may_drive) viol++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic qwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        may_drive = 1'b0;
        m_sda = 1'b1; qwait(Q);
        m_scl = 1'b1; qwait(Q);
        m_sda = 1'b0; qwait(Q);
        m_scl = 1'b0; qwait(Q);
    endtask

    task automatic bus_stop();
        may_drive = 1'b0;
        m_sda = 1'b0; qwait(Q);
        m_scl = 1'b1; qwait(Q);
        m_sda = 1'b1; qwait(2*Q);
    endtask

    task automatic wbit(input logic b);
        may_drive = 1'b0;
        m_sda = b;    qwait(Q);
        m_scl = 1'b1; qwait(2*Q);
        m_scl = 1'b0; qwait(Q);
    endtask

    task automatic rbit(input bit allow, output logic b);
        may_drive = allow;
        m_sda = 1'b1; qwait(Q);
        m_scl = 1'b1; qwait(Q);
        b = sda_line; qwait(Q);
        m_scl = 1'b0; qwait(Q);
    endtask

    task automatic tx_byte(input logic [7:0] v, input bit allow, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(allow, b);
        ack = (b == 1'b0);
    endtask

    task automatic rx_byte(input bit give_ack, input bit allow, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(allow, b);
            v[i] = b;
        end
        wbit(~give_ack);
    endtask

    // page write with in-page wrap applied to the model (R11, R9)
    task automatic write_txn(input int addr, input logic [7:0] data[$], input string tag);
        bit ack;
        bus_start();
        tx_byte({4'b1010, 3'((addr >> 8) & 7), 1'b0}, 1'b1, ack);
        chk(ack, {tag, " R6 select ack"}, ack, 1);
        tx_byte(8'(addr & 'hFF), 1'b1, ack);
        chk(ack, {tag, " R6 word address ack"}, ack, 1);
        foreach (data[i]) begin
            int a;
            tx_byte(data[i], 1'b1, ack);
            chk(ack, {tag, " R6 data ack"}, ack, 1);
            a = (addr & ~'hF) | ((addr + i) & 'hF);
            if (!wp) model_mem[a] = data[i];
        end
        bus_stop();
    endtask

    task automatic read_rest(input int n, input string tag);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            rx_byte(i != n - 1, 1'b1, v);
            chk(v == exp_at(model_ptr), tag, v, exp_at(model_ptr));
            model_ptr = (model_ptr + 1) & 'h7FF;
        end
        bus_stop();
    endtask

    task automatic random_read(input int addr, input int n, input string tag);
        bit ack;
        bus_start();
        tx_byte({4'b1010, 3'((addr >> 8) & 7), 1'b0}, 1'b1, ack);
        chk(ack, {tag, " R5 dummy write select ack"}, ack, 1);
        tx_byte(8'(addr & 'hFF), 1'b1, ack);
        chk(ack, {tag, " R6 word address ack"}, ack, 1);
        model_ptr = addr & 'h7FF;
        bus_start();
        tx_byte(8'hA1, 1'b1, ack);
        chk(ack, {tag, " R5 read select ack"}, ack, 1);
        read_rest(n, tag);
    endtask

    initial begin
        logic [7:0] d[$];
        logic [7:0] v;
        bit         ack;
        logic       b;

        qwait(10);
        chk(sda_oe == 1'b0, "R8 oe low in reset", sda_oe, 0);
        rst_n = 1'b1;
        qwait(10);
        chk(sda_oe == 1'b0, "R8 oe low after reset", sda_oe, 0);

        // R1: select byte clocked with no start condition
        for (int i = 7; i >= 0; i--) wbit(8'hA0 >> i);
        rbit(1'b0, b);
        chk(b == 1'b1, "R1 no ack without start", b, 1);
        bus_stop();

        // R8: erased contents
        random_read('h000, 1, "R8 erased 0x000");
        random_read('h7FF, 1, "R8 erased 0x7FF");

        // R3: wrong device code, then a full released byte
        bus_start();
        tx_byte(8'hB0, 1'b0, ack);
        chk(!ack, "R3 foreign code not acked", ack, 0);
        tx_byte(8'h00, 1'b0, ack);
        chk(!ack, "R3 stays released", ack, 0);
        bus_stop();

        // R4 / R12: single write, busy window, then readback
        d = {8'h3C};
        write_txn('h123, d, "R4 write 0x123");
        bus_start();
        tx_byte(8'hA0, 1'b0, ack);
        chk(!ack, "R12 no ack while committing", ack, 0);
        bus_stop();
        qwait(WAIT);
        random_read('h123, 1, "R4 R12 readback 0x123");
        random_read('h023, 1, "R4 page bits select 0x023");

        // R11: page write wrapping inside its page
        d = {8'hA1, 8'hB2, 8'hC3, 8'hD4};
        write_txn('h25E, d, "R11 page write");
        qwait(WAIT);
        random_read('h250, 16, "R11 R7 page contents");

        // R10: wrap of the read pointer and current-address read
        d = {8'h5A};
        write_txn('h7FF, d, "R10 write 0x7FF");
        qwait(WAIT);
        d = {8'hA5, 8'h77};
        write_txn('h000, d, "R10 write 0x000");
        qwait(WAIT);
        random_read('h7FF, 2, "R10 wrap read");
        bus_start();
        tx_byte(8'hA1, 1'b1, ack);
        chk(ack, "R10 current read select ack", ack, 1);
        read_rest(1, "R10 current address read");

        // R7: after not-acknowledge the slave stays off the bus
        random_read('h123, 1, "R7 read before release");
        bus_start();
        tx_byte(8'hA1, 1'b1, ack);
        rx_byte(1'b0, 1'b1, v);
        chk(v == exp_at(model_ptr), "R7 byte before nack", v, exp_at(model_ptr));
        rx_byte(1'b0, 1'b0, v);
        chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
        bus_stop();

        // R9: write protect
        wp = 1'b1;
        d = {8'h11};
        write_txn('h300, d, "R9 protected write");
        qwait(WAIT);
        wp = 1'b0;
        random_read('h300, 1, "R9 protected location unchanged");

        qwait(20);
        chk(viol == 0, "R2 no pull-low with SCL high outside slave phases", viol, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R12 run did not finish actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule